// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer with a programmable clock divider. Software programs it through four small registers: a vector entry, an initial count, a read-only current count and a divide configuration. The timer counts divided ticks down from the initial count. When the countdown expires, the block raises a one-cycle interrupt request. The request carries the vector number and delivery mode held in the vector entry, and it is suppressed when the entry is masked.

There are two modes. In one-shot mode the timer fires once and then sits at zero. In periodic mode the timer reloads itself every initial+1 ticks. A free-running prescaler makes the divided tick, and writing the initial count clears that prescaler, so the timing of each run starts exactly at the load. The current count can be read back on any cycle.

Top module: `lapic_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked), and the initial count, current count and divide configuration all read 0. No request is raised.
- R2: The divide register stores only bits 3, 1 and 0 of a write. Writing 0xFFFF_FFFF reads back as 0xB.
- R3: The tick period is 2^s input cycles, where s = ({bit3,bit1,bit0} + 1) mod 8. Code 0x0 divides by 2, code 0x1 by 4, code 0x8 by 32 and code 0xB by 1.
- R4: The current count reads live. It equals the initial count minus the ticks elapsed since the load. In one-shot mode it stops at 0.
- R5: In one-shot mode with a nonzero initial count N, exactly one request is raised, on tick N+1 after the load. The request carries vector entry bits 7:0 on irqVector and bits 10:8 on irqMode.
- R6: When vector entry bit 17 is set (periodic mode), the count reloads to the initial value after reaching 0. A period lasts initial+1 ticks, and a request is raised at each reload.
- R7: An initial count of 0 never raises a request, in either mode.
- R8: When vector entry bit 16 is set, no request is raised, but the count keeps running.
- R9: Writing the initial count restarts the countdown from the written value and clears the prescaler. It also replaces any expiry still pending from the earlier load.
- R10: If the vector entry is unmasked before expiry, the pending expiry still fires, and it uses the vector entry's contents at the moment of expiry.
- R11: Each request lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write select: 0 vector entry, 1 initial count, 2 current count (ignored), 3 divide |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 2 | Read select, same encoding as the write select |
| regRdData | output | 32 | Combinational read data |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector number sent with the request |
| irqMode | output | 3 | Delivery mode sent with the request |

## Verification
A scoreboard predicts the exact cycle of every request from the load cycle, the divide code and the initial count. One-shot runs under four divide codes separate correct shift decoding from off-by-one and wrong-bit errors. A periodic run, with a readback in the middle of a period, separates an initial+1 period from an initial period. Further runs cover a zero initial count, masking, unmasking before expiry, and reloading part-way through a run on an even-divide clock. Together these show whether the load resets the prescaler and cancels the old expiry, and whether the mask takes effect on exactly the expiry tick.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
  localparam int REG_W = 32;
  localparam int VEC_PERIODIC_BIT = 17;
  localparam int VEC_MASK_BIT = 16;
  localparam int VEC_MODE_LSB = 8;
  localparam logic [REG_W-1:0] DIV_WR_MASK = 32'h0000_000B;
  localparam logic [REG_W-1:0] VEC_RESET = 32'h0001_0000;

  typedef enum logic [1:0] {
    REG_VECTOR  = 2'd0,
    REG_INIT    = 2'd1,
    REG_CURRENT = 2'd2,
    REG_DIVIDE  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic loadInit;
    logic countDown;
    logic reload;
    logic fire;
  } tmrStrobe_t;
endpackage

// File: rtl/lapic_timer_ctrl.sv
module lapic_timer_ctrl
  import lapic_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initWr,
  input  logic       initWrNonZero,
  input  logic       tick,
  input  logic       curIsZero,
  input  logic       initIsZero,
  input  logic       periodic,
  input  logic       masked,
  output tmrStrobe_t strobe
);
  logic armed;
  logic armedNext;

  always_comb begin
    strobe = '0;
    armedNext = armed;
    if (initWr) begin
      strobe.loadInit = 1'b1;
      armedNext = initWrNonZero;
    end else if (tick) begin
      if (!curIsZero) begin
        strobe.countDown = 1'b1;
      end else if (periodic) begin
        strobe.reload = 1'b1;
        strobe.fire = !initIsZero && !masked;
      end else if (armed) begin
        strobe.fire = !masked;
        armedNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else armed <= armedNext;
  end
endmodule

// File: rtl/lapic_timer_dp.sv
module lapic_timer_dp
  import lapic_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int PRESC_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regWrAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [1:0]         regRdAddr,
  output logic [REG_W-1:0]   regRdData,
  input  tmrStrobe_t         strobe,
  output logic               initWr,
  output logic               initWrNonZero,
  output logic               tick,
  output logic               curIsZero,
  output logic               initIsZero,
  output logic               periodic,
  output logic               masked,
  output logic [REG_W-1:0]   vecEntry,
  output logic [COUNT_W-1:0] initCount,
  output logic [COUNT_W-1:0] curCount,
  output logic               irqValid,
  output logic [7:0]         irqVector,
  output logic [2:0]         irqMode
);
  localparam int SHIFT_W = $clog2(PRESC_W + 1);

  logic [REG_W-1:0]   divCfg;
  logic [PRESC_W-1:0] prescaler;
  logic [PRESC_W-1:0] lowMask;
  logic [2:0]         divCode;
  logic [SHIFT_W-1:0] shiftAmt;

  assign initWr        = regWrEn && (regWrAddr == REG_INIT);
  assign initWrNonZero = |regWrData[COUNT_W-1:0];
  assign periodic      = vecEntry[VEC_PERIODIC_BIT];
  assign masked        = vecEntry[VEC_MASK_BIT];
  assign curIsZero     = (curCount == '0);
  assign initIsZero    = (initCount == '0);

  assign divCode  = {divCfg[3], divCfg[1:0]};
  assign shiftAmt = SHIFT_W'(3'(divCode + 3'd1));

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) begin
      lowMask[i] = (i < int'(shiftAmt));
    end
  end

  assign tick = ((prescaler & lowMask) == lowMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecEntry <= VEC_RESET;
      divCfg   <= '0;
    end else if (regWrEn) begin
      if (regWrAddr == REG_VECTOR) vecEntry <= regWrData;
      if (regWrAddr == REG_DIVIDE) divCfg <= regWrData & DIV_WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCount <= '0;
      curCount  <= '0;
      prescaler <= '0;
    end else begin
      prescaler <= strobe.loadInit ? '0 : prescaler + 1'b1;
      if (strobe.loadInit) begin
        initCount <= regWrData[COUNT_W-1:0];
        curCount  <= regWrData[COUNT_W-1:0];
      end else if (strobe.reload) begin
        curCount <= initCount;
      end else if (strobe.countDown) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
      irqMode   <= '0;
    end else begin
      irqValid <= strobe.fire;
      if (strobe.fire) begin
        irqVector <= vecEntry[7:0];
        irqMode   <= vecEntry[VEC_MODE_LSB +: 3];
      end
    end
  end

  always_comb begin
    unique case (regSel_t'(regRdAddr))
      REG_VECTOR:  regRdData = vecEntry;
      REG_INIT:    regRdData = REG_W'(initCount);
      REG_CURRENT: regRdData = REG_W'(curCount);
      REG_DIVIDE:  regRdData = divCfg;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int PRESC_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdAddr,
  output logic [31:0] regRdData,
  output logic        irqValid,
  output logic [7:0]  irqVector,
  output logic [2:0]  irqMode
);
  tmrStrobe_t         strobe;
  logic               initWr;
  logic               initWrNonZero;
  logic               tick;
  logic               curIsZero;
  logic               initIsZero;
  logic               periodic;
  logic               masked;
  logic [31:0]        vecEntry;
  logic [COUNT_W-1:0] initCount;
  logic [COUNT_W-1:0] curCount;

  lapic_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initWr(initWr), .initWrNonZero(initWrNonZero),
    .tick(tick), .curIsZero(curIsZero), .initIsZero(initIsZero),
    .periodic(periodic), .masked(masked), .strobe(strobe)
  );

  lapic_timer_dp #(.COUNT_W(COUNT_W), .PRESC_W(PRESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .strobe(strobe), .initWr(initWr), .initWrNonZero(initWrNonZero),
    .tick(tick), .curIsZero(curIsZero), .initIsZero(initIsZero),
    .periodic(periodic), .masked(masked), .vecEntry(vecEntry),
    .initCount(initCount), .curCount(curCount), .irqValid(irqValid),
    .irqVector(irqVector), .irqMode(irqMode)
  );
endmodule

// File: rtl/lapic_timer_chk.sv
module lapic_timer_chk #(
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               irqValid,
  input logic [7:0]         irqVector,
  input logic [2:0]         irqMode,
  input logic [31:0]        vecEntry,
  input logic [COUNT_W-1:0] initCount,
  input logic [COUNT_W-1:0] curCount,
  input logic               tick,
  input logic               initWr
);
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(vecEntry[16]));

  assert_payload_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector == $past(vecEntry[7:0]) && irqMode == $past(vecEntry[10:8])));

  assert_zero_init_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(initCount) != '0));

  assert_oneshot_monotone_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(initWr) && !$past(vecEntry[17])) |-> (curCount <= $past(curCount)));

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tick) && $past(vecEntry[17]) && ($past(curCount) == '0) && !$past(initWr))
      |-> (curCount == $past(initCount)));
endmodule

bind lapic_timer lapic_timer_chk #(.COUNT_W(COUNT_W)) u_chk (.*);

// File: tb/sim_lapic_timer.sv
module sim_lapic_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        irqValid;
  logic [7:0]  irqVector;
  logic [2:0]  irqMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  lapic_timer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .irqValid(irqValid), .irqVector(irqVector), .irqMode(irqMode)
  );

  typedef struct {
    int         at;
    logic [7:0] vec;
    logic [2:0] mode;
    string      req;
  } expPulse_t;

  expPulse_t expQ[$];
  expPulse_t monE;
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  string quietReq = "R1";
  bit    prevIrq = 1'b0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a request appears.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (irqValid && prevIrq) check(1'b0, "R11", "request held two cycles", 1, 0);
      if (irqValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, quietReq, "unexpected request at cycle", cyc, 0);
        end else begin
          monE = expQ.pop_front();
          check(cyc == monE.at, monE.req, "request cycle", cyc, monE.at);
          check(irqVector == monE.vec, monE.req, "request vector", irqVector, monE.vec);
          check(irqMode == monE.mode, monE.req, "request mode", irqMode, monE.mode);
        end
      end
      prevIrq <= irqValid;
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d, output int loadAt);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
    loadAt = cyc;
  endtask

  task automatic waitTo(input int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp,
                         input string req, input string what);
    regRdAddr = a;
    #1;
    check(regRdData == exp, req, what, regRdData, exp);
  endtask

  task automatic expectAt(input int at, input logic [7:0] v, input logic [2:0] m,
                          input string req);
    expPulse_t e;
    e.at = at; e.vec = v; e.mode = m; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic checkDrained(input string req);
    check(expQ.size() == 0, req, "requests still outstanding", expQ.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R1", "watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    int n2;
    int dummy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    rdCheck(2'd0, 32'h0001_0000, "R1", "vector entry after reset");
    rdCheck(2'd1, 32'h0, "R1", "initial count after reset");
    rdCheck(2'd2, 32'h0, "R1", "current count after reset");
    rdCheck(2'd3, 32'h0, "R1", "divide after reset");
    check(irqValid == 1'b0, "R1", "request after reset", irqValid, 0);

    // R2 divide write mask
    wrReg(2'd3, 32'hFFFF_FFFF, dummy);
    @(negedge clk);
    rdCheck(2'd3, 32'h0000_000B, "R2", "divide readback");

    // R5/R4 one-shot, divide by 1
    quietReq = "R5";
    wrReg(2'd0, 32'h0000_0245, dummy);
    wrReg(2'd1, 32'd5, n);
    expectAt(n + 6, 8'h45, 3'd2, "R5");
    waitTo(n + 2);
    rdCheck(2'd2, 32'd3, "R4", "live current count");
    waitTo(n + 7);
    check(irqValid == 1'b0, "R11", "request after its cycle", irqValid, 0);
    waitTo(n + 12);
    rdCheck(2'd2, 32'd0, "R4", "one-shot count holds at zero");
    checkDrained("R5");

    // R3 divider codes
    quietReq = "R3";
    wrReg(2'd3, 32'h0, dummy);
    wrReg(2'd1, 32'd3, n);
    expectAt(n + 8, 8'h45, 3'd2, "R3");
    waitTo(n + 10);
    checkDrained("R3");
    wrReg(2'd3, 32'h1, dummy);
    wrReg(2'd1, 32'd2, n);
    expectAt(n + 12, 8'h45, 3'd2, "R3");
    waitTo(n + 14);
    checkDrained("R3");
    wrReg(2'd3, 32'h8, dummy);
    wrReg(2'd1, 32'd1, n);
    expectAt(n + 64, 8'h45, 3'd2, "R3");
    waitTo(n + 70);
    checkDrained("R3");

    // R6 periodic, then R8 mask with count still running
    quietReq = "R6";
    wrReg(2'd3, 32'hB, dummy);
    wrReg(2'd1, 32'd0, dummy);
    wrReg(2'd0, 32'h0002_0381, dummy);
    wrReg(2'd1, 32'd3, n);
    expectAt(n + 4, 8'h81, 3'd3, "R6");
    expectAt(n + 8, 8'h81, 3'd3, "R6");
    expectAt(n + 12, 8'h81, 3'd3, "R6");
    waitTo(n + 5);
    rdCheck(2'd2, 32'd2, "R6", "periodic count after reload");
    waitTo(n + 12);
    quietReq = "R8";
    wrReg(2'd0, 32'h0003_0381, dummy);
    waitTo(n + 30);
    rdCheck(2'd2, 32'd1, "R8", "masked periodic count keeps running");
    checkDrained("R6");

    // R7 zero initial count in both modes
    quietReq = "R7";
    wrReg(2'd1, 32'd0, dummy);
    wrReg(2'd0, 32'h0002_0381, n);
    waitTo(n + 20);
    wrReg(2'd0, 32'h0000_0381, n);
    waitTo(n + 20);
    rdCheck(2'd2, 32'd0, "R7", "count with zero initial value");
    checkDrained("R7");

    // R8 masked one-shot
    quietReq = "R8";
    wrReg(2'd0, 32'h0001_0381, dummy);
    wrReg(2'd1, 32'd4, n);
    waitTo(n + 20);
    rdCheck(2'd2, 32'd0, "R8", "masked one-shot still counted down");
    checkDrained("R8");

    // R9 restart during a run on a divide-by-2 clock
    quietReq = "R9";
    wrReg(2'd0, 32'h0000_0381, dummy);
    wrReg(2'd3, 32'h0, dummy);
    wrReg(2'd1, 32'd10, n);
    waitTo(n + 2);
    wrReg(2'd1, 32'd2, n2);
    expectAt(n2 + 6, 8'h81, 3'd3, "R9");
    waitTo(n2 + 2);
    rdCheck(2'd2, 32'd1, "R9", "count after restart");
    waitTo(n2 + 30);
    checkDrained("R9");

    // R10 unmask before expiry, new payload used
    quietReq = "R10";
    wrReg(2'd3, 32'hB, dummy);
    wrReg(2'd0, 32'h0001_0000, dummy);
    wrReg(2'd1, 32'd6, n);
    waitTo(n + 1);
    wrReg(2'd0, 32'h0000_0511, dummy);
    expectAt(n + 7, 8'h11, 3'd5, "R10");
    waitTo(n + 12);
    checkDrained("R10");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule